// File: doc/BRIEF.md
# Data-Stream Framing Token Parser

This block sits behind the descrambler of a 128b/130b receive path and walks the symbol stream of data blocks one byte per cycle. It recognises idle, short link-packet, long transaction-packet, nullify and end-of-stream tokens. It counts how many symbols of the current packet are still owed, and marks the first and last symbol of every packet with a type tag. There are no explicit end symbols: a packet's extent comes either from its first symbol or from a length field protected by a check code and a parity bit. Packets may run across block boundaries.

A block boundary strobe and the two-bit sync header arrive with the first symbol of each block. The parser checks every header. It also checks that an ordered-set block only follows a correctly placed end-of-stream token. Any violation produces a one-cycle framing-error pulse that asks the link controller for recovery. After the pulse, delivery stops until the controller asserts a resume input. All outputs are registered and describe the symbol accepted in the previous cycle.

Top module: `frame_tok_parser`

## Requirements
- R1: A symbol 0x00 in a token slot is consumed as one idle/pad symbol and produces no marker and no error.
- R2: A token symbol 0xF0 opens a link packet of 8 symbols in total: pkt_start_o with pkt_type_o = 2 follows that symbol, and pkt_end_o follows the 7th symbol after it.
- R3: A token symbol with low nibble 0xF opens a 4-symbol header. Byte 0 bits 7:4 hold length bits 3:0. Byte 1 bits 6:0 hold length bits 10:4 and bit 7 holds parity. Byte 2 bits 3:0 hold the check code and bits 7:4 the sequence high bits. Byte 3 holds the sequence low bits. The check code must equal len[3:0] ^ len[7:4] ^ {0,len[10:8]}. The XOR of the 11 length bits, the 4 check bits and the parity bit must be 0. When the header is valid, pkt_start_o with pkt_type_o = 1 follows byte 3.
- R4: The length L counts dwords of the whole packet including its header and 4-byte trailer: pkt_end_o follows the (4L-4)th symbol after the header, also when the packet spans block boundaries.
- R5: If the last dword of a long packet is 0xC0 four times, pkt_end_o comes with pkt_null_o high. If its first byte is 0xC0 and a later byte of that dword is not, a framing error is raised on that byte.
- R6: A header with L below 5, a wrong check code or wrong parity raises a framing error on byte 3 and no start marker.
- R7: A token symbol that is not 0x00, 0xF0, a low-nibble-0xF value or (at the end-of-stream slot) 0x1F raises a framing error. This includes 0xC0.
- R8: The sequence 0x1F 0x80 0x90 0x00 starting at block position BLK_SYMS-4 (12 by default) is an end-of-stream token. Any ordered-set blocks that follow are ignored, and the next data block parses tokens again. A wrong byte inside it is a framing error.
- R9: A sync header of 00b or 11b, an ordered-set header (01b) without a preceding end-of-stream token, or a data header (10b) right after that token raises a framing error.
- R10: frame_err_o is a one-cycle pulse. After it, every symbol and header is ignored with no marker and no further error until resume_i, whose own cycle's symbol is discarded.
- R11: A cycle with sym_vld_i low changes neither the parse state nor the block position.
- R12: During and right after reset all outputs are low and pkt_type_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sym_vld_i | input | 1 | Symbol present this cycle |
| sym_i | input | 8 | Descrambled symbol |
| blk_start_i | input | 1 | Symbol is the first of a block |
| sync_i | input | 2 | Sync header of the block, used with blk_start_i |
| resume_i | input | 1 | Leave the halted state after a framing error |
| pkt_start_o | output | 1 | Packet begins (after its token is complete) |
| pkt_end_o | output | 1 | Last symbol of the packet was received |
| pkt_type_o | output | 2 | 0 none, 1 transaction packet, 2 link packet |
| pkt_null_o | output | 1 | Ending packet was nullified |
| frame_err_o | output | 1 | Framing error pulse, recovery request |

## Verification
The assertions take for granted that blk_start_i arrives exactly every BLK_SYMS valid symbols. They also take for granted that resume_i is only raised when the controller wants parsing to restart. The bench keeps a block position counter of its own, derives every strobe from it, and pads with idle symbols so that tokens fall where it intends. It raises resume_i only in cycles with sym_vld_i low, after an expected error. Its sweeps run through all 256 token values and through header lengths on both sides of the minimum.

// File: rtl/frame_tok_pkg.sv
package frame_tok_pkg;
  localparam int LEN_W = 11;

  typedef enum logic [1:0] {PT_NONE = 2'd0, PT_TLP = 2'd1, PT_DLLP = 2'd2} pkt_type_e;

  typedef enum logic [2:0] {
    S_TOK, S_STP, S_TLP, S_SDP, S_EDS, S_OS, S_HALT
  } parse_st_e;

  localparam logic [7:0] SYM_IDL  = 8'h00;
  localparam logic [7:0] SYM_SDP  = 8'hF0;
  localparam logic [7:0] SYM_NULL = 8'hC0;
  localparam logic [7:0] SYM_EOS0 = 8'h1F;
  localparam logic [1:0] SH_DATA  = 2'b10;
  localparam logic [1:0] SH_OS    = 2'b01;

  function automatic logic [7:0] eos_byte(input logic [1:0] idx);
    case (idx)
      2'd1:    eos_byte = 8'h80;
      2'd2:    eos_byte = 8'h90;
      default: eos_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] len_chk(input logic [LEN_W-1:0] len);
    len_chk = len[3:0] ^ len[7:4] ^ {1'b0, len[10:8]};
  endfunction
endpackage

// File: rtl/frame_tok_pos.sv
module frame_tok_pos #(
  parameter int BLK_SYMS = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  logic blk_start_i,
  output logic eos_slot_o
);
  localparam int POS_W = $clog2(BLK_SYMS);
  localparam logic [POS_W-1:0] LAST = POS_W'(BLK_SYMS - 1);
  localparam logic [POS_W-1:0] EOS  = POS_W'(BLK_SYMS - 4);

  logic [POS_W-1:0] pos_q, cur;

  assign cur        = blk_start_i ? '0 : pos_q;
  assign eos_slot_o = (cur == EOS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pos_q <= '0;
    else if (vld_i) pos_q <= (cur == LAST) ? '0 : cur + 1'b1;
  end

  // input rule: block strobes come every BLK_SYMS valid symbols
  p_blk_aligned_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && blk_start_i) |-> (pos_q == '0));
  p_pos_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pos_q));
endmodule

// File: rtl/frame_tok_stp_chk.sv
module frame_tok_stp_chk
  import frame_tok_pkg::*;
#(
  parameter int MIN_DW = 5,
  parameter int REM_W  = LEN_W + 2
) (
  input  logic [LEN_W-1:0] len_i,
  input  logic [3:0]       chk_i,
  input  logic             par_i,
  output logic             ok_o,
  output logic [REM_W-1:0] rem_o
);
  logic code_ok, par_ok, len_ok;

  assign code_ok = (chk_i == len_chk(len_i));
  assign par_ok  = ~^{len_i, chk_i, par_i};
  assign len_ok  = (len_i >= LEN_W'(MIN_DW));
  assign ok_o    = code_ok && par_ok && len_ok;
  // body symbols after the 4-symbol header
  assign rem_o   = {len_i, 2'b00} - REM_W'(4);
endmodule

// File: rtl/frame_tok_parser.sv
module frame_tok_parser
  import frame_tok_pkg::*;
#(
  parameter int BLK_SYMS = 16,
  parameter int MIN_DW   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sym_vld_i,
  input  logic [7:0] sym_i,
  input  logic       blk_start_i,
  input  logic [1:0] sync_i,
  input  logic       resume_i,
  output logic       pkt_start_o,
  output logic       pkt_end_o,
  output logic [1:0] pkt_type_o,
  output logic       pkt_null_o,
  output logic       frame_err_o
);
  localparam int REM_W = LEN_W + 2;

  parse_st_e        st_q, st_d, eff;
  logic [REM_W-1:0] rem_q, rem_d, chk_rem;
  logic [1:0]       idx_q, idx_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [3:0]       code_q, code_d;
  logic             par_q, par_d, null_q, null_d, eos_q, eos_d;
  pkt_type_e        type_q, type_d;
  logic             start, stop, nul, err, hdr_bad, os_blk, eos_slot, hdr_ok;

  frame_tok_pos #(.BLK_SYMS(BLK_SYMS)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .vld_i(sym_vld_i),
    .blk_start_i(blk_start_i), .eos_slot_o(eos_slot)
  );

  frame_tok_stp_chk #(.MIN_DW(MIN_DW), .REM_W(REM_W)) u_chk (
    .len_i(len_q), .chk_i(code_q), .par_i(par_q), .ok_o(hdr_ok), .rem_o(chk_rem)
  );

  always_comb begin
    st_d = st_q; rem_d = rem_q; idx_d = idx_q; len_d = len_q; code_d = code_q;
    par_d = par_q; null_d = null_q; eos_d = eos_q; type_d = type_q;
    start = 1'b0; stop = 1'b0; nul = 1'b0; err = 1'b0;
    hdr_bad = 1'b0; os_blk = 1'b0; eff = st_q;
    if (st_q == S_HALT) begin
      if (resume_i) begin st_d = S_TOK; eos_d = 1'b0; end
    end else if (sym_vld_i) begin
      if (blk_start_i) begin
        if (sync_i == SH_OS) begin
          if (eos_q || st_q == S_OS) os_blk = 1'b1;
          else hdr_bad = 1'b1;
        end else if (sync_i == SH_DATA) begin
          if (eos_q) hdr_bad = 1'b1;
          else if (st_q == S_OS) eff = S_TOK;
        end else hdr_bad = 1'b1;
      end
      if (hdr_bad) err = 1'b1;
      else if (os_blk) begin st_d = S_OS; eos_d = 1'b0; end
      else begin
        case (eff)
          S_TOK: begin
            st_d = S_TOK;
            if (eos_slot && sym_i == SYM_EOS0) begin st_d = S_EDS; idx_d = 2'd1; end
            else if (sym_i == SYM_IDL) ;
            else if (sym_i == SYM_SDP) begin
              start = 1'b1; type_d = PT_DLLP; rem_d = REM_W'(7); st_d = S_SDP;
            end else if (sym_i[3:0] == 4'hF) begin
              len_d[3:0] = sym_i[7:4]; idx_d = 2'd1; st_d = S_STP;
            end else err = 1'b1;
          end
          S_STP: begin
            idx_d = idx_q + 2'd1;
            case (idx_q)
              2'd1: begin len_d[10:4] = sym_i[6:0]; par_d = sym_i[7]; end
              2'd2: code_d = sym_i[3:0];
              default: begin
                if (hdr_ok) begin
                  start = 1'b1; type_d = PT_TLP; rem_d = chk_rem; st_d = S_TLP;
                end else err = 1'b1;
              end
            endcase
          end
          S_TLP: begin
            if (rem_q == REM_W'(4)) null_d = (sym_i == SYM_NULL);
            else if (rem_q < REM_W'(4) && null_q && sym_i != SYM_NULL) err = 1'b1;
            rem_d = rem_q - 1'b1;
            if (!err && rem_q == REM_W'(1)) begin
              stop = 1'b1; nul = null_q; st_d = S_TOK;
            end
          end
          S_SDP: begin
            rem_d = rem_q - 1'b1;
            if (rem_q == REM_W'(1)) begin stop = 1'b1; st_d = S_TOK; end
          end
          S_EDS: begin
            idx_d = idx_q + 2'd1;
            if (sym_i != eos_byte(idx_q)) err = 1'b1;
            else if (idx_q == 2'd3) begin eos_d = 1'b1; st_d = S_TOK; end
          end
          default: ;  // ordered-set content is not parsed
        endcase
      end
      if (err) st_d = S_HALT;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_TOK; rem_q <= '0; idx_q <= '0; len_q <= '0; code_q <= '0;
      par_q <= 1'b0; null_q <= 1'b0; eos_q <= 1'b0; type_q <= PT_NONE;
      pkt_start_o <= 1'b0; pkt_end_o <= 1'b0; pkt_null_o <= 1'b0; frame_err_o <= 1'b0;
    end else begin
      st_q <= st_d; rem_q <= rem_d; idx_q <= idx_d; len_q <= len_d; code_q <= code_d;
      par_q <= par_d; null_q <= null_d; eos_q <= eos_d; type_q <= type_d;
      pkt_start_o <= start; pkt_end_o <= stop; pkt_null_o <= nul; frame_err_o <= err;
    end
  end

  assign pkt_type_o = type_q;

  p_start_type_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_start_o |-> (pkt_type_o != PT_NONE));
  p_start_end_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pkt_start_o && pkt_end_o));
  p_null_tlp_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_null_o |-> (pkt_end_o && pkt_type_o == PT_TLP));
  p_err_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !frame_err_o);
  p_err_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |=> !(pkt_start_o || pkt_end_o));
  p_err_no_marker_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> !(pkt_start_o || pkt_end_o));
endmodule

// File: tb/frame_tok_parser_bench.sv
module frame_tok_parser_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sym_vld = 1'b0, blk_start = 1'b0, resume = 1'b0;
  logic [7:0] sym = 8'h00;
  logic [1:0] sync = 2'b10;
  logic pkt_start, pkt_end, pkt_null, frame_err;
  logic [1:0] pkt_type;

  int n_chk = 0, n_bad = 0, bpos = 0;
  logic [1:0] nsync = 2'b10;

  always #10 clk = ~clk;

  frame_tok_parser u_frame_tok_parser (
    .clk_i(clk), .rst_ni(rst_n), .sym_vld_i(sym_vld), .sym_i(sym),
    .blk_start_i(blk_start), .sync_i(sync), .resume_i(resume),
    .pkt_start_o(pkt_start), .pkt_end_o(pkt_end), .pkt_type_o(pkt_type),
    .pkt_null_o(pkt_null), .frame_err_o(frame_err)
  );

  task automatic chk(string rq, bit s, bit e, int t, bit nl, bit er);
    bit bad;
    n_chk++;
    bad = (pkt_start != s) || (pkt_end != e) || (pkt_null != nl) || (frame_err != er);
    if ((s || e) && pkt_type != 2'(t)) bad = 1'b1;
    if (bad) begin
      n_bad++;
      $display("FAIL %s: got s%0b e%0b t%0d n%0b err%0b, expected s%0b e%0b t%0d n%0b err%0b",
               rq, pkt_start, pkt_end, pkt_type, pkt_null, frame_err, s, e, t, nl, er);
    end
  endtask

  task automatic put(logic [7:0] v, string rq, bit s = 0, bit e = 0, int t = 0,
                     bit nl = 0, bit er = 0);
    sym_vld = 1'b1; sym = v; blk_start = (bpos == 0); sync = nsync; resume = 1'b0;
    @(negedge clk);
    bpos = (bpos + 1) % 16;
    sym_vld = 1'b0; blk_start = 1'b0;
    chk(rq, s, e, t, nl, er);
  endtask

  task automatic gap(string rq);
    sym_vld = 1'b0; sym = 8'hF0; blk_start = 1'b1; sync = 2'b00;
    @(negedge clk);
    blk_start = 1'b0;
    chk(rq, 0, 0, 0, 0, 0);
  endtask

  task automatic do_resume();
    sym_vld = 1'b0; resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    chk("R10", 0, 0, 0, 0, 0);
  endtask

  task automatic idle_to(int p);
    while (bpos != p) put(8'h00, "R1");
  endtask

  task automatic skip_eos_slot();
    if (bpos == 12) put(8'h00, "R1");
  endtask

  // lo: byte 0 value; bad 1 = parity flip, 2 = check code flip; nul: trailer 0xC0
  task automatic send_tlp(logic [7:0] b0, logic [6:0] hi, int bad, bit nul);
    logic [10:0] len;
    logic [3:0] code;
    logic p;
    bit fail;
    int body;
    len = {hi, b0[7:4]};
    code = len[3:0] ^ len[7:4] ^ {1'b0, len[10:8]};
    p = ^{len, code};
    if (bad == 1) p = ~p;
    if (bad == 2) code = code ^ 4'h1;
    fail = (len < 5) || (bad != 0);
    skip_eos_slot();
    put(b0, "R3");
    put({p, hi}, "R3");
    put({4'h3, code}, "R3");
    if (fail) begin
      put(8'h21, "R6", 0, 0, 0, 0, 1);
      do_resume();
      return;
    end
    put(8'h21, "R3", 1, 0, 1);
    body = 4 * int'(len) - 4;
    for (int k = 0; k < body; k++) begin
      logic [7:0] d;
      d = (nul && k >= body - 4) ? 8'hC0 : 8'h5A;
      put(d, "R4", 0, k == body - 1, 1, nul && k == body - 1, 0);
    end
  endtask

  task automatic send_dllp(int gaps);
    skip_eos_slot();
    put(8'hF0, "R2", 1, 0, 2);
    for (int k = 0; k < 7; k++) begin
      if (k == 3) for (int g = 0; g < gaps; g++) gap("R11");
      put(8'h33, "R2", 0, k == 6, 2);
    end
  endtask

  task automatic send_eos();
    idle_to(12);
    put(8'h1F, "R8"); put(8'h80, "R8"); put(8'h90, "R8"); put(8'h00, "R8");
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", 0, 0, 0, 0, 0);
    if (pkt_type != 2'd0) begin n_bad++; $display("FAIL R12: type %0d expected 0", pkt_type); end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", 0, 0, 0, 0, 0);

    // R1 idles, R2 link packets, R11 stalls
    for (int k = 0; k < 16; k++) put(8'h00, "R1");
    send_dllp(0);
    send_dllp(3);

    // R4 lengths around the minimum, crossing block boundaries
    for (int l = 0; l < 24; l++) send_tlp({4'(l), 4'hF}, 7'(l >> 4), 0, 0);
    send_tlp(8'h6F, 7'h00, 0, 1);            // R5 nullified
    send_tlp(8'h9F, 7'h01, 0, 0);            // length 25
    send_tlp(8'h7F, 7'h00, 1, 0);            // R6 parity
    send_tlp(8'h7F, 7'h00, 2, 0);            // R6 check code

    // R5 partial nullify: last dword C0 then 5A
    skip_eos_slot();
    put(8'h5F, "R5"); put(8'h00, "R5"); put({4'h0, 4'h5}, "R5");
    put(8'h07, "R5", 1, 0, 1);
    for (int k = 0; k < 12; k++) put(8'h5A, "R5", 0, 0, 1);
    put(8'hC0, "R5", 0, 0, 1);
    put(8'h5A, "R5", 0, 0, 0, 0, 1);
    do_resume();

    // R7 sweep of every token value
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = 8'(v);
      skip_eos_slot();
      if (b == 8'h00) put(b, "R1");
      else if (b == 8'hF0) send_dllp(0);
      else if (b[3:0] == 4'hF) send_tlp(b, 7'h00, 0, 0);
      else begin put(b, "R7", 0, 0, 0, 0, 1); do_resume(); end
    end

    // R10 halt ignores everything until resume
    skip_eos_slot();
    put(8'h42, "R10", 0, 0, 0, 0, 1);
    idle_to(15);
    put(8'hF0, "R10");
    nsync = 2'b11;
    put(8'hF0, "R10");
    nsync = 2'b10;
    put(8'h00, "R10");
    do_resume();
    send_dllp(0);

    // R8 end-of-stream then ordered-set blocks then data
    send_eos();
    nsync = 2'b01;
    for (int k = 0; k < 32; k++) put(8'hF0, "R8");
    nsync = 2'b10;
    send_dllp(0);
    // R8 wrong byte in end-of-stream token
    idle_to(12);
    put(8'h1F, "R8"); put(8'h80, "R8"); put(8'h91, "R8", 0, 0, 0, 0, 1);
    do_resume();

    // R9 header faults
    idle_to(0);
    nsync = 2'b00; put(8'h00, "R9", 0, 0, 0, 0, 1); nsync = 2'b10; do_resume();
    idle_to(0);
    nsync = 2'b11; put(8'h00, "R9", 0, 0, 0, 0, 1); nsync = 2'b10; do_resume();
    idle_to(0);
    nsync = 2'b01; put(8'hAA, "R9", 0, 0, 0, 0, 1); nsync = 2'b10; do_resume();
    send_eos();
    put(8'h00, "R9", 0, 0, 0, 0, 1);
    do_resume();
    send_dllp(0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule